// File: doc/BRIEF.md
# Four-Channel Incremental Position Counter Bank

This block counts motion pulses from up to four incremental position sensors. Each channel holds a signed-agnostic 32-bit up/down count that wraps modulo 2^32. Per channel, the two input pins are read in one of two ways. In quadrature mode they are an A/B pair decoded on every edge of both signals, which gives four counts per input cycle. In clock/direction mode the first pin is a step clock and the second gives the direction. All pins, including the per-channel external capture pin, pass through two-flop synchronizers before any edge is detected.

A small register interface controls the bank. The host uses it to choose each channel's mode, to enable counting, to clear counts and sticky decode errors, and to copy counts into per-channel snapshot registers. It can copy one channel or every channel on the same clock edge, and it reads the snapshots back while counting goes on. A rising edge on a channel's external capture pin also takes a snapshot, but only while the host has set that channel's capture-enable bit.

Quadrature decoding is a four-state machine per channel. The states are PH_00, PH_01, PH_10 and PH_11, named after the last sampled {A,B} pair. From any state, each new sample is classified as one of four moves:
- MV_HOLD: the sample is the same as the state.
- MV_FWD: the next phase of the sequence 00→10→11→01→00. The count goes up.
- MV_REV: the previous phase of that sequence. The count goes down.
- MV_SKIP: both bits changed at once. The sample is illegal.

After every sample the state moves to the sampled phase.

Top module: `enc_counter_bank`

Register map (address width 3 for four channels):
- Address 0, configuration (read/write):
  - bits [3:0]: mode per channel (1 = clock/direction, 0 = quadrature)
  - bits [7:4]: count enable per channel
  - bits [11:8]: external capture enable per channel
- Address 1, command (write): bit fields are given in R6, R7, R8 and R10. A read of address 1 returns the error flags in bits [3:0].
- Addresses 2 to 5: snapshot of channels 0 to 3 (read only).
- Any other address reads as zero.

## Requirements
- R1: After reset, every count, every snapshot, the configuration register and all error flags read as zero.
- R2: In quadrature mode with the enable set, a pin change moves the count in the third clock after the change (two synchronizer stages plus the counter register). The phase sequence {A,B} = 00→10→11→01→00 adds one per step, the reverse order subtracts one per step, and the count never changes by more than one per cycle.
- R3: In clock/direction mode, each rising edge of the synchronized A pin adds one when the B pin is 1 and subtracts one when it is 0. Falling edges of A have no effect.
- R4: Configuration bit ch selects clock/direction mode (1) or quadrature mode (0) for channel ch, independently per channel. The configuration register reads back what was written.
- R5: While enable bit 4+ch is 0, channel ch does not count, but its decoder keeps tracking the pins, so setting the enable again causes no spurious step.
- R6: Writing 1 to command bit ch zeroes count ch on that write edge. The clear wins over a step in the same cycle.
- R7: Writing 1 to command bit 4+ch copies count ch into snapshot ch on that edge, capturing the value from before any step in the same cycle. Other snapshots are untouched.
- R8: Writing 1 to command bit 8 copies all four counts into their snapshots on the same edge.
- R9: A rising edge of the synchronized external capture pin of channel ch copies count ch into its snapshot only while configuration bit 8+ch is 1. Otherwise the edge is ignored.
- R10: In quadrature mode, a sample in which A and B both change leaves the count unchanged and sets sticky error flag ch (address 1, bit ch). Writing 1 to command bit 9+ch clears the flag.
- R11: The count wraps modulo 2^32: stepping down from 0 gives FFFFFFFF, and stepping up from FFFFFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 4 | Per-channel A pin, or step clock in clock/direction mode |
| enc_b | input | 4 | Per-channel B pin, or direction in clock/direction mode |
| ext_cap | input | 4 | Per-channel external capture pin |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |

## Verification
The bench walks channel 0 through forward and reverse quadrature phases and down through zero, where a design with a wrong step direction or a saturating counter would read back the wrong value. It sends double-bit-change samples, which a careless decoder would count as two steps or fail to flag. It issues a clear and a snapshot in exactly the cycle a step arrives: a design that let the step beat the clear would read 1 instead of 0, and a snapshot taken after the step would show the stepped value. It also pulses an external capture pin with its enable clear, and toggles the pins of a disabled channel, to catch captures and counts that leak through their gates.

// File: rtl/encbank_pkg.sv
package encbank_pkg;

    // Quadrature decoder phase, encoded as the sampled {A,B} pair
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } quad_ph_e;

    // Classification of one new sample against the current phase
    typedef enum logic [1:0] {
        MV_HOLD,
        MV_FWD,
        MV_REV,
        MV_SKIP
    } quad_mv_e;

    localparam int unsigned ADDR_CFG  = 0;
    localparam int unsigned ADDR_CMD  = 1;
    localparam int unsigned ADDR_LAT0 = 2;

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign d_out = sync_q;

endmodule

// File: rtl/enc_quad_fsm.sv
module enc_quad_fsm
    import encbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_s,
    input  logic b_s,
    output logic fwd,
    output logic rev,
    output logic skip
);

    quad_ph_e   state_q;
    quad_mv_e   move;
    logic [1:0] smp;

    assign smp = {a_s, b_s};

    // State register: always follows the latest sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_00;
        end else begin
            state_q <= quad_ph_e'(smp);
        end
    end

    // Move classification and outputs
    always_comb begin
        move = MV_HOLD;
        unique case (state_q)
            PH_00: begin
                case (smp)
                    2'b10:   move = MV_FWD;
                    2'b01:   move = MV_REV;
                    2'b11:   move = MV_SKIP;
                    default: move = MV_HOLD;
                endcase
            end
            PH_10: begin
                case (smp)
                    2'b11:   move = MV_FWD;
                    2'b00:   move = MV_REV;
                    2'b01:   move = MV_SKIP;
                    default: move = MV_HOLD;
                endcase
            end
            PH_11: begin
                case (smp)
                    2'b01:   move = MV_FWD;
                    2'b10:   move = MV_REV;
                    2'b00:   move = MV_SKIP;
                    default: move = MV_HOLD;
                endcase
            end
            PH_01: begin
                case (smp)
                    2'b00:   move = MV_FWD;
                    2'b11:   move = MV_REV;
                    2'b10:   move = MV_SKIP;
                    default: move = MV_HOLD;
                endcase
            end
        endcase
        fwd  = (move == MV_FWD);
        rev  = (move == MV_REV);
        skip = (move == MV_SKIP);
    end

endmodule

// File: rtl/enc_channel.sv
module enc_channel #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_s,
    input  logic          b_s,
    input  logic          x_s,
    input  logic          mode_cd,
    input  logic          cnt_en,
    input  logic          xcap_en,
    input  logic          clr,
    input  logic          snap,
    input  logic          err_clr,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lat,
    output logic          err
);

    logic          q_fwd;
    logic          q_rev;
    logic          q_skip;
    logic          a_prev_q;
    logic          x_prev_q;
    logic          cd_rise;
    logic          x_rise;
    logic          step_up;
    logic          step_dn;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lat_q;
    logic          err_q;

    enc_quad_fsm u_quad (
        .clk   (clk),
        .rst_n (rst_n),
        .a_s   (a_s),
        .b_s   (b_s),
        .fwd   (q_fwd),
        .rev   (q_rev),
        .skip  (q_skip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_prev_q <= 1'b0;
            x_prev_q <= 1'b0;
        end else begin
            a_prev_q <= a_s;
            x_prev_q <= x_s;
        end
    end

    assign cd_rise = a_s & ~a_prev_q;
    assign x_rise  = x_s & ~x_prev_q;

    always_comb begin
        if (mode_cd) begin
            step_up = cnt_en & cd_rise & b_s;
            step_dn = cnt_en & cd_rise & ~b_s;
        end else begin
            step_up = cnt_en & q_fwd;
            step_dn = cnt_en & q_rev;
        end
    end

    // Count register: clear has priority over a step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step_up) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (step_dn) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Snapshot register: takes the pre-step value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (snap || (xcap_en && x_rise)) begin
            lat_q <= cnt_q;
        end
    end

    // Sticky decode error: a new error wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (!mode_cd && q_skip) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
    assign lat = lat_q;
    assign err = err_q;

endmodule

// File: rtl/enc_counter_bank.sv
module enc_counter_bank
    import encbank_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int CW  = 32,
    localparam int AW  = $clog2(NCH + 2),
    localparam int CFW = 3 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] enc_a,
    input  logic [NCH-1:0] enc_b,
    input  logic [NCH-1:0] ext_cap,
    input  logic           host_we,
    input  logic [AW-1:0]  host_addr,
    input  logic [CW-1:0]  host_wdata,
    output logic [CW-1:0]  host_rdata
);

    localparam int OFS_EN   = NCH;
    localparam int OFS_XC   = 2 * NCH;
    localparam int BIT_ALL  = 2 * NCH;
    localparam int OFS_ECLR = 2 * NCH + 1;

    logic [CFW-1:0] pins_s;
    logic [NCH-1:0] a_s;
    logic [NCH-1:0] b_s;
    logic [NCH-1:0] x_s;
    logic [CFW-1:0] cfg_q;
    logic           cmd_hit;
    logic [NCH-1:0] clr_v;
    logic [NCH-1:0] lat_v;
    logic [NCH-1:0] errclr_v;
    logic [NCH-1:0] err_w;
    logic [CW-1:0]  cnt_w [NCH];
    logic [CW-1:0]  lat_w [NCH];

    enc_sync #(.W(CFW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ext_cap, enc_b, enc_a}),
        .d_out (pins_s)
    );

    assign a_s = pins_s[NCH-1:0];
    assign b_s = pins_s[2*NCH-1:NCH];
    assign x_s = pins_s[3*NCH-1:2*NCH];

    // Configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (host_we && host_addr == AW'(ADDR_CFG)) begin
            cfg_q <= host_wdata[CFW-1:0];
        end
    end

    // Command strobes act on the write edge itself
    assign cmd_hit = host_we && (host_addr == AW'(ADDR_CMD));

    always_comb begin
        clr_v    = '0;
        lat_v    = '0;
        errclr_v = '0;
        if (cmd_hit) begin
            clr_v    = host_wdata[NCH-1:0];
            lat_v    = host_wdata[OFS_EN +: NCH] | {NCH{host_wdata[BIT_ALL]}};
            errclr_v = host_wdata[OFS_ECLR +: NCH];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        enc_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_s     (a_s[g]),
            .b_s     (b_s[g]),
            .x_s     (x_s[g]),
            .mode_cd (cfg_q[g]),
            .cnt_en  (cfg_q[OFS_EN + g]),
            .xcap_en (cfg_q[OFS_XC + g]),
            .clr     (clr_v[g]),
            .snap    (lat_v[g]),
            .err_clr (errclr_v[g]),
            .cnt     (cnt_w[g]),
            .lat     (lat_w[g]),
            .err     (err_w[g])
        );
    end

    // Read multiplexer
    always_comb begin
        host_rdata = '0;
        if (host_addr == AW'(ADDR_CFG)) begin
            host_rdata = CW'(cfg_q);
        end else if (host_addr == AW'(ADDR_CMD)) begin
            host_rdata = CW'(err_w);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (host_addr == AW'(ADDR_LAT0 + i)) begin
                    host_rdata = lat_w[i];
                end
            end
        end
    end

endmodule

// File: rtl/enc_counter_bank_chk.sv
module enc_counter_bank_chk #(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int CFW = 3 * NCH
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  cnt_w [NCH],
    input logic [CW-1:0]  lat_w [NCH],
    input logic [NCH-1:0] err_w,
    input logic [NCH-1:0] clr_v,
    input logic [NCH-1:0] lat_v,
    input logic [NCH-1:0] errclr_v,
    input logic [CFW-1:0] cfg_q
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_v[g] |=> (cnt_w[g] == '0)); // R6
        AST_SNAP_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            lat_v[g] |=> (lat_w[g] == $past(cnt_w[g]))); // R7
        AST_SNAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (!lat_v[g] && !cfg_q[2*NCH + g]) |=> $stable(lat_w[g])); // R9
        AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_v[g] |=> ((CW'(cnt_w[g] - $past(cnt_w[g])) == CW'(0)) ||
                           (CW'(cnt_w[g] - $past(cnt_w[g])) == CW'(1)) ||
                           (CW'(cnt_w[g] - $past(cnt_w[g])) == {CW{1'b1}}))); // R2
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (err_w[g] && !errclr_v[g]) |=> err_w[g]); // R10
    end

endmodule

bind enc_counter_bank enc_counter_bank_chk #(.NCH(NCH), .CW(CW), .CFW(CFW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_w    (cnt_w),
    .lat_w    (lat_w),
    .err_w    (err_w),
    .clr_v    (clr_v),
    .lat_v    (lat_v),
    .errclr_v (errclr_v),
    .cfg_q    (cfg_q)
);

// File: tb/enc_counter_bank_tb_top.sv
module enc_counter_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CW  = 32;
    localparam int AW  = 3;

    // Vector: {A,B} for channel 0 [34:33], expected count [32:1], expected error [0]
    localparam int NVEC = 12;
    localparam logic [34:0] VEC [NVEC] = '{
        {2'b10, 32'd1,          1'b0},
        {2'b11, 32'd2,          1'b0},
        {2'b01, 32'd3,          1'b0},
        {2'b00, 32'd4,          1'b0},
        {2'b01, 32'd3,          1'b0},
        {2'b11, 32'd2,          1'b0},
        {2'b10, 32'd1,          1'b0},
        {2'b00, 32'd0,          1'b0},
        {2'b01, 32'hFFFF_FFFF,  1'b0},
        {2'b00, 32'd0,          1'b0},
        {2'b11, 32'd0,          1'b1},
        {2'b00, 32'd0,          1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pa = '0;
    logic [NCH-1:0] pb = '0;
    logic [NCH-1:0] px = '0;
    logic           we = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [CW-1:0]  wdata = '0;
    logic [CW-1:0]  rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    enc_counter_bank #(.NCH(NCH), .CW(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_a      (pa),
        .enc_b      (pb),
        .ext_cap    (px),
        .host_we    (we),
        .host_addr  (addr),
        .host_wdata (wdata),
        .host_rdata (rdata)
    );

    task automatic chk(input string rq, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic host_rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic snap_rd(input int ch, output logic [CW-1:0] d);
        host_wr(3'd1, CW'(1) << (NCH + ch));
        host_rd(AW'(2 + ch), d);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [CW-1:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        host_rd(3'd0, v); chk("R1 cfg", v, '0);
        host_rd(3'd1, v); chk("R1 err", v, '0);
        for (int c = 0; c < NCH; c++) begin
            host_rd(AW'(2 + c), v); chk("R1 snap", v, '0);
        end

        // R4: ch1, ch3 clock/direction; ch0, ch1, ch3 enabled; ch2 disabled
        host_wr(3'd0, 32'h0000_00BA);
        host_rd(3'd0, v); chk("R4 cfg readback", v, 32'h0000_00BA);

        // R2 / R10 / R11: quadrature table on channel 0
        for (int k = 0; k < NVEC; k++) begin
            pa[0] = VEC[k][34];
            pb[0] = VEC[k][33];
            tick(4);
            snap_rd(0, v); chk("R2 quad count", v, VEC[k][32:1]);
            host_rd(3'd1, v); chk("R10 err flag", {31'd0, v[0]}, {31'd0, VEC[k][0]});
        end

        // R10: error clear through command bit 9
        host_wr(3'd1, 32'h0000_0200);
        host_rd(3'd1, v); chk("R10 err clear", {31'd0, v[0]}, 32'd0);

        // R6: clear in the same cycle as a step (step would give 1)
        pa[0] = 1'b1; pb[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        host_wr(3'd1, 32'h0000_0001);
        tick(2);
        snap_rd(0, v); chk("R6 clear beats step", v, 32'd0);
        pa[0] = 1'b1; pb[0] = 1'b1;
        tick(4);
        snap_rd(0, v); chk("R6 counts after clear", v, 32'd1);

        // R7: snapshot in the same cycle as a step takes the old value
        pa[0] = 1'b0; pb[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        host_wr(3'd1, 32'h0000_0010);
        host_rd(3'd2, v); chk("R7 snap pre-step", v, 32'd1);
        tick(2);
        snap_rd(0, v); chk("R7 snap after step", v, 32'd2);
        host_rd(3'd3, v); chk("R7 other snap untouched", v, 32'd0);

        // R3: clock/direction on channel 1: three up edges, one down edge
        pb[1] = 1'b1;
        tick(4);
        for (int k = 0; k < 3; k++) begin
            pa[1] = 1'b1; tick(4);
            pa[1] = 1'b0; tick(4);
        end
        pb[1] = 1'b0; tick(4);
        pa[1] = 1'b1; tick(4);
        pa[1] = 1'b0; tick(4);
        snap_rd(1, v); chk("R3 clk/dir count", v, 32'd2);

        // R5: channel 2 disabled, full quadrature cycle
        pa[2] = 1'b1; pb[2] = 1'b0; tick(4);
        pa[2] = 1'b1; pb[2] = 1'b1; tick(4);
        pa[2] = 1'b0; pb[2] = 1'b1; tick(4);
        pa[2] = 1'b0; pb[2] = 1'b0; tick(4);
        snap_rd(2, v); chk("R5 disabled no count", v, 32'd0);
        host_wr(3'd0, 32'h0000_00FA);
        tick(2);
        snap_rd(2, v); chk("R5 no spurious step on enable", v, 32'd0);
        pa[2] = 1'b1; tick(4);
        snap_rd(2, v); chk("R5 counts once enabled", v, 32'd1);

        // R8 / R11: ch3 steps down from zero, ch0 and ch1 step up, latch all
        pb[3] = 1'b0;
        pa[3] = 1'b1; tick(4);
        pa[3] = 1'b0; tick(4);
        pa[0] = 1'b0; pb[0] = 1'b0; tick(4);
        pb[1] = 1'b1; tick(4);
        pa[1] = 1'b1; tick(4);
        pa[1] = 1'b0; tick(4);
        host_wr(3'd1, 32'h0000_0100);
        host_rd(3'd2, v); chk("R8 all ch0", v, 32'd3);
        host_rd(3'd3, v); chk("R8 all ch1", v, 32'd3);
        host_rd(3'd4, v); chk("R8 all ch2", v, 32'd1);
        host_rd(3'd5, v); chk("R11 wrap down ch3", v, 32'hFFFF_FFFF);

        // R11: wrap up to zero; R9 capture pin ignored while disabled
        pb[3] = 1'b1;
        pa[3] = 1'b1; tick(4);
        pa[3] = 1'b0; tick(4);
        px[3] = 1'b1; tick(4);
        host_rd(3'd5, v); chk("R9 capture ignored", v, 32'hFFFF_FFFF);
        px[3] = 1'b0; tick(4);
        host_wr(3'd0, 32'h0000_08FA);
        px[3] = 1'b1; tick(4);
        host_rd(3'd5, v); chk("R9 capture enabled / R11 wrap up", v, 32'd0);
        host_rd(3'd4, v); chk("R9 other snap untouched", v, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule